// File: doc/BRIEF.md
# Flash Program/Erase Status Generator

This block stands in for the embedded controller of a byte-wide, sector-erasable flash memory. A command decoder upstream presents single-cycle start pulses for a byte program, a sector-erase confirm or a whole-array erase, together with the target address and data byte. The block then times the operation with parameterised cycle counters, retries it when verify fails, and finally updates a register-array model of the storage. Each sector can be marked protected, and protected sectors are never modified.

While an operation is in flight, every read strobe returns a handshake byte instead of array contents. Bit 7 is a data-polling bit, bit 6 changes value on each read, bit 5 is a sticky failure flag, and bit 3 tells a host whether the sector-collection window is still open. An erase can be paused so that other sectors can be read, and later resumed. A fault-injection input forces the verify step to fail, which is the only way to reach the failure path.

Top module: `pe_status_gen`

## Requirements
- R1: After reset the block is idle (`busy`=0, `suspended`=0, `err`=0) and every byte of the array reads FFh.
- R2: A byte program with `fault_inj` low keeps `busy` high for exactly `PROG_CYC` cycles and leaves the byte equal to its old value AND the written data, so bits can only go from 1 to 0.
- R3: A read strobe captures one byte into `rdata` at the next clock edge. While a status byte is returned, bit 7 is the inverse of bit 7 of the data being programmed during a program, or 0 during any erase. Bit 6 is the toggle bit, bit 5 is the error flag and bit 3 is the erase-started flag. Bits 4, 2, 1 and 0 are don't-care.
- R4: The first status read of an operation returns bit 6 = 0, and each further status read returns the opposite value. While suspended, bit 6 does not change.
- R5: Once idle, reads return array contents again. After a program, bit 7 of the byte read therefore shows the true programmed bit.
- R6: A sector-erase confirm taken while idle opens a window of `WIN_CYC` cycles, during which bit 3 reads 0. Each further confirm taken inside the window adds that sector to the erase set and restarts the window.
- R7: When the window expires, bit 3 reads 1 and each selected unprotected sector is set to FFh, at `ERASE_CYC` cycles per sector. A whole-array erase skips the window and erases every unprotected sector. Bytes in sectors outside the set are not changed.
- R8: `suspend_req` during erasing raises `suspended` and freezes the erase timer. While suspended, reads of sectors outside the erase set return array data. `resume_req` continues the erase.
- R9: A program to a protected sector, or an erase whose set contains no unprotected sector, shows status for `IGN_CYC` cycles and then returns to idle with the array unchanged.
- R10: `fault_inj` is sampled at the end of each attempt. After `RETRY_MAX` failed attempts, `err` rises and stays high, `busy` stays high, status bit 5 reads 1 and the target is left unchanged. Only `rd_reset` clears this state and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Start a byte program at `addr` with `wdata` |
| serase_start | input | 1 | Sector-erase confirm for the sector holding `addr` |
| berase_start | input | 1 | Start an erase of all unprotected sectors |
| suspend_req | input | 1 | Pause a running erase |
| resume_req | input | 1 | Continue a paused erase |
| rd_reset | input | 1 | Read/reset command; clears the failure state |
| addr | input | ADDR_W | Target address for commands and reads |
| wdata | input | 8 | Byte to program |
| prot_mask | input | 2**SECT_W | One bit per sector; 1 means protected |
| fault_inj | input | 1 | Test input: make the verify of the current attempt fail |
| rd_stb | input | 1 | Read strobe |
| rdata | output | 8 | Array byte or status byte |
| busy | output | 1 | An operation, window, ignore period or failure state is active |
| suspended | output | 1 | Erase is paused |
| err | output | 1 | Sticky failure flag |

## Verification
The bench builds the block with a 256-byte array split into four sectors, and shortens all durations to a few tens of cycles: program 20, erase 40 per sector, window 40, ignore period 25, with three attempts allowed. With these values a bench can reach in a few thousand cycles the window restart, multi-sector and whole-array erases, a suspend in the middle of an erase, and retry exhaustion. The window value leaves a margin of ten cycles on each side. This lets a read that falls after the first window would have ended still fall inside the restarted one.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    PE_IDLE,
    PE_PROG,
    PE_WIN,
    PE_ERASE,
    PE_SUSP,
    PE_IGN,
    PE_FAIL
  } pe_state_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TGL  = 6;
  localparam int BIT_ERR  = 5;
  localparam int BIT_ERS  = 3;
endpackage

// File: rtl/pe_cycle_timer.sv
module pe_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (en && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en && (cnt_q == CNT_W'(1));

  // a running timer must have been loaded with a non-zero length
  assert_timer_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt_q != '0);
endmodule

// File: rtl/pe_byte_store.sv
module pe_byte_store #(
  parameter int ADDR_W = 8,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wipe_en,
  input  logic [SECT_W-1:0] wipe_sect,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SHIFT = ADDR_W - SECT_W;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (wipe_en && SECT_W'(i >> SHIFT) == wipe_sect)
        mem_d[i] = 8'hFF;
      else if (wr_en && wr_addr == ADDR_W'(i))
        mem_d[i] = mem_q[i] & wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data = mem_q[rd_addr];

  // program write and sector wipe come from exclusive controller states
  assert_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wipe_en));
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 2000,
  parameter int ERASE_CYC = 300000,
  parameter int WIN_CYC   = 20000,
  parameter int IGN_CYC   = 20000,
  parameter int RETRY_MAX = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_start,
  input  logic                    serase_start,
  input  logic                    berase_start,
  input  logic                    suspend_req,
  input  logic                    resume_req,
  input  logic                    rd_reset,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  input  logic [(1<<SECT_W)-1:0]  prot_mask,
  input  logic                    fault_inj,
  input  logic                    rd_stb,
  output logic [7:0]              rdata,
  output logic                    busy,
  output logic                    suspended,
  output logic                    err
);
  localparam int NSECT = 1 << SECT_W;
  localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_B = (WIN_CYC > IGN_CYC) ? WIN_CYC : IGN_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int TRY_W = $clog2(RETRY_MAX + 1);

  function automatic logic [SECT_W-1:0] low_idx(input logic [NSECT-1:0] m);
    logic [SECT_W-1:0] r;
    r = '0;
    for (int i = NSECT - 1; i >= 0; i--) if (m[i]) r = SECT_W'(i);
    return r;
  endfunction

  pe_state_e         state_q, state_d;
  logic              is_prog_q, is_prog_d;
  logic [ADDR_W-1:0] tgt_addr_q, tgt_addr_d;
  logic [7:0]        tgt_data_q, tgt_data_d;
  logic [NSECT-1:0]  sel_q, sel_d;
  logic [SECT_W-1:0] cur_q, cur_d;
  logic [TRY_W-1:0]  try_q, try_d;
  logic              err_q, err_d;
  logic              tgl_q, tgl_d;
  logic [7:0]        rdata_q, rdata_d;

  logic              tmr_load, tmr_en, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              wr_en, wipe_en;
  logic [7:0]        arr_byte;

  logic [SECT_W-1:0] cmd_sect;
  logic [NSECT-1:0]  cmd_hot, free_mask, eff_mask, rem_mask;
  logic              last_try, show_status;
  logic [7:0]        status_byte;

  assign cmd_sect  = addr[ADDR_W-1 -: SECT_W];
  assign cmd_hot   = NSECT'(1) << cmd_sect;
  assign free_mask = ~prot_mask;
  assign eff_mask  = sel_q & free_mask;
  assign rem_mask  = sel_q & ~(NSECT'(1) << cur_q);
  assign last_try  = (try_q == TRY_W'(RETRY_MAX - 1));

  pe_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .en(tmr_en), .done(tmr_done)
  );

  pe_byte_store #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(tgt_addr_q), .wr_data(tgt_data_q),
    .wipe_en(wipe_en), .wipe_sect(cur_q),
    .rd_addr(addr), .rd_data(arr_byte)
  );

  assign tmr_en = (state_q == PE_PROG) || (state_q == PE_WIN) ||
                  (state_q == PE_ERASE) || (state_q == PE_IGN);

  // status byte and read path
  always_comb begin
    status_byte          = 8'h00;
    status_byte[BIT_POLL] = is_prog_q ? ~tgt_data_q[7] : 1'b0;
    status_byte[BIT_TGL]  = tgl_q;
    status_byte[BIT_ERR]  = err_q;
    status_byte[BIT_ERS]  = (state_q == PE_ERASE) || (state_q == PE_SUSP) ||
                            (state_q == PE_FAIL && !is_prog_q);
    show_status = (state_q != PE_IDLE) &&
                  !(state_q == PE_SUSP && !sel_q[cmd_sect]);
    rdata_d = rdata_q;
    if (rd_stb) rdata_d = show_status ? status_byte : arr_byte;
  end

  // controller next state
  always_comb begin
    state_d    = state_q;
    is_prog_d  = is_prog_q;
    tgt_addr_d = tgt_addr_q;
    tgt_data_d = tgt_data_q;
    sel_d      = sel_q;
    cur_d      = cur_q;
    try_d      = try_q;
    err_d      = err_q;
    tgl_d      = tgl_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    wr_en      = 1'b0;
    wipe_en    = 1'b0;

    unique case (state_q)
      PE_IDLE: begin
        if (prog_start) begin
          is_prog_d  = 1'b1;
          tgt_addr_d = addr;
          tgt_data_d = wdata;
          try_d      = '0;
          tgl_d      = 1'b0;
          tmr_load   = 1'b1;
          if (prot_mask[cmd_sect]) begin
            state_d = PE_IGN;
            tmr_val = CNT_W'(IGN_CYC);
          end else begin
            state_d = PE_PROG;
            tmr_val = CNT_W'(PROG_CYC);
          end
        end else if (berase_start) begin
          is_prog_d = 1'b0;
          try_d     = '0;
          tgl_d     = 1'b0;
          tmr_load  = 1'b1;
          if (free_mask == '0) begin
            sel_d   = '0;
            state_d = PE_IGN;
            tmr_val = CNT_W'(IGN_CYC);
          end else begin
            sel_d   = free_mask;
            cur_d   = low_idx(free_mask);
            state_d = PE_ERASE;
            tmr_val = CNT_W'(ERASE_CYC);
          end
        end else if (serase_start) begin
          is_prog_d = 1'b0;
          tgl_d     = 1'b0;
          sel_d     = cmd_hot;
          state_d   = PE_WIN;
          tmr_load  = 1'b1;
          tmr_val   = CNT_W'(WIN_CYC);
        end
      end

      PE_PROG: begin
        if (tmr_done) begin
          if (fault_inj) begin
            if (last_try) begin
              state_d = PE_FAIL;
              err_d   = 1'b1;
            end else begin
              try_d    = try_q + 1'b1;
              tmr_load = 1'b1;
              tmr_val  = CNT_W'(PROG_CYC);
            end
          end else begin
            wr_en   = 1'b1;
            state_d = PE_IDLE;
          end
        end
      end

      PE_WIN: begin
        if (serase_start) begin
          sel_d    = sel_q | cmd_hot;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WIN_CYC);
        end else if (tmr_done) begin
          tmr_load = 1'b1;
          try_d    = '0;
          if (eff_mask == '0) begin
            sel_d   = '0;
            state_d = PE_IGN;
            tmr_val = CNT_W'(IGN_CYC);
          end else begin
            sel_d   = eff_mask;
            cur_d   = low_idx(eff_mask);
            state_d = PE_ERASE;
            tmr_val = CNT_W'(ERASE_CYC);
          end
        end
      end

      PE_ERASE: begin
        if (tmr_done) begin
          if (fault_inj) begin
            if (last_try) begin
              state_d = PE_FAIL;
              err_d   = 1'b1;
            end else begin
              try_d    = try_q + 1'b1;
              tmr_load = 1'b1;
              tmr_val  = CNT_W'(ERASE_CYC);
            end
          end else begin
            wipe_en = 1'b1;
            sel_d   = rem_mask;
            if (rem_mask == '0) begin
              state_d = PE_IDLE;
            end else begin
              cur_d    = low_idx(rem_mask);
              try_d    = '0;
              tmr_load = 1'b1;
              tmr_val  = CNT_W'(ERASE_CYC);
            end
          end
        end else if (suspend_req) begin
          state_d = PE_SUSP;
        end
      end

      PE_SUSP: begin
        if (resume_req) state_d = PE_ERASE;
      end

      PE_IGN: begin
        if (tmr_done) begin
          sel_d   = '0;
          state_d = PE_IDLE;
        end
      end

      PE_FAIL: begin
        if (rd_reset) begin
          err_d   = 1'b0;
          sel_d   = '0;
          state_d = PE_IDLE;
        end
      end

      default: state_d = PE_IDLE;
    endcase

    if (rd_stb && show_status && state_q != PE_SUSP) tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PE_IDLE;
      is_prog_q  <= 1'b0;
      tgt_addr_q <= '0;
      tgt_data_q <= 8'hFF;
      sel_q      <= '0;
      cur_q      <= '0;
      try_q      <= '0;
      err_q      <= 1'b0;
      tgl_q      <= 1'b0;
      rdata_q    <= 8'hFF;
    end else begin
      state_q    <= state_d;
      is_prog_q  <= is_prog_d;
      tgt_addr_q <= tgt_addr_d;
      tgt_data_q <= tgt_data_d;
      sel_q      <= sel_d;
      cur_q      <= cur_d;
      try_q      <= try_d;
      err_q      <= err_d;
      tgl_q      <= tgl_d;
      rdata_q    <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign busy      = (state_q != PE_IDLE);
  assign suspended = (state_q == PE_SUSP);
  assign err       = err_q;

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !rd_reset |=> err_q);

  assert_fail_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PE_FAIL && !rd_reset |=> busy && err);

  assert_susp_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PE_ERASE && suspend_req && !tmr_done |=> suspended);

  assert_tgl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PE_SUSP && $past(state_q == PE_SUSP) |-> $stable(tgl_q));
endmodule

// File: tb/tb_pe_status_gen.sv
`timescale 1ns/1ps
module tb_pe_status_gen;
  localparam int AW = 8, SW = 2;
  localparam int P_CYC = 20, E_CYC = 40, W_CYC = 40, I_CYC = 25, TRIES = 3;
  localparam logic [7:0] SMASK = 8'hE8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_start = 0, serase_start = 0, berase_start = 0;
  logic suspend_req = 0, resume_req = 0, rd_reset = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] prot_mask = '0;
  logic fault_inj = 0, rd_stb = 0;
  logic [7:0] rdata;
  logic busy, suspended, err;

  always #2.5 clk = ~clk;

  pe_status_gen #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(P_CYC), .ERASE_CYC(E_CYC),
    .WIN_CYC(W_CYC), .IGN_CYC(I_CYC), .RETRY_MAX(TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .serase_start(serase_start),
    .berase_start(berase_start), .suspend_req(suspend_req), .resume_req(resume_req),
    .rd_reset(rd_reset), .addr(addr), .wdata(wdata), .prot_mask(prot_mask),
    .fault_inj(fault_inj), .rd_stb(rd_stb), .rdata(rdata), .busy(busy),
    .suspended(suspended), .err(err));

  typedef struct { logic [7:0] exp; logic [7:0] msk; string tag; } item_t;
  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  bit exp_tgl;

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: queue the expected byte, then strobe
  task automatic rd(input logic [7:0] a, input logic [7:0] e, input logic [7:0] m,
                    input string tag);
    item_t it;
    it.exp = e; it.msk = m; it.tag = tag;
    sb.push_back(it);
    addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // status read: bench owns the toggle prediction
  task automatic rd_st(input logic [7:0] a, input logic [7:0] base, input bit flips,
                       input string tag);
    logic [7:0] e;
    e = base | (exp_tgl ? 8'h40 : 8'h00);
    rd(a, e, SMASK, tag);
    if (flips) exp_tgl = ~exp_tgl;
  endtask

  // monitor: pops one item per strobe and compares after the capture edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_stb) begin
        item_t it;
        @(negedge clk);
        it = sb.pop_front();
        chk(int'(rdata & it.msk), int'(it.exp & it.msk), it.tag);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_free(input int lim, input string tag);
    int n = 0;
    while (busy && n < lim) begin @(negedge clk); n++; end
    chk(int'(busy), 0, tag);
  endtask

  task automatic start_prog(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; prog_start = 1'b1; exp_tgl = 0;
    @(negedge clk); prog_start = 1'b0;
  endtask

  task automatic start_se(input logic [7:0] a, input bit fresh);
    addr = a; serase_start = 1'b1; if (fresh) exp_tgl = 0;
    @(negedge clk); serase_start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    idle(3); rst_n = 1'b1; idle(2);
    // R1 reset state
    chk(busy, 0, "R1 busy"); chk(suspended, 0, "R1 suspended"); chk(err, 0, "R1 err");
    rd(8'h00, 8'hFF, 8'hFF, "R1 byte 00"); rd(8'hFF, 8'hFF, 8'hFF, "R1 byte FF");

    // R2 program duration and AND semantics
    start_prog(8'h05, 8'h5A);
    n = 0; while (busy && n < 1000) begin @(negedge clk); n++; end
    chk(n, P_CYC, "R2 program busy cycles");
    rd(8'h05, 8'h5A, 8'hFF, "R5 read after program");
    start_prog(8'h05, 8'hF0);
    rd_st(8'h33, 8'h00, 1, "R3 poll bit inverse of 1");
    rd_st(8'h05, 8'h00, 1, "R4 toggle second read");
    rd_st(8'h05, 8'h00, 1, "R4 toggle third read");
    wait_free(200, "R2 program ends");
    rd(8'h05, 8'h50, 8'hFF, "R2 bits only cleared");
    start_prog(8'h41, 8'h00); wait_free(200, "R2 program 41");
    rd(8'h41, 8'h00, 8'hFF, "R5 true bit7 after program");

    // R6 window and restart, R7 multi-sector erase
    start_se(8'h41, 1);
    rd_st(8'h41, 8'h00, 1, "R6 window bit3 low");
    idle(18);
    start_se(8'h85, 0);
    idle(29);
    rd_st(8'h00, 8'h00, 1, "R6 window restarted");
    idle(30);
    rd_st(8'h00, 8'h08, 1, "R7 erase started bit3");
    wait_free(400, "R7 erase completes");
    rd(8'h41, 8'hFF, 8'hFF, "R7 sector1 wiped");
    rd(8'h85, 8'hFF, 8'hFF, "R7 sector2 wiped");
    rd(8'h05, 8'h50, 8'hFF, "R7 sector0 kept");

    // R8 suspend during whole-array erase, sector 0 protected
    start_prog(8'hC0, 8'h3C); wait_free(200, "R2 program C0");
    prot_mask = 4'b0001;
    berase_start = 1'b1; exp_tgl = 0; @(negedge clk); berase_start = 1'b0;
    idle(8);
    suspend_req = 1'b1; @(negedge clk); suspend_req = 1'b0;
    chk(suspended, 1, "R8 suspended flag");
    rd(8'h05, 8'h50, 8'hFF, "R8 other sector readable");
    rd_st(8'hC0, 8'h08, 0, "R4 steady while suspended a");
    rd_st(8'hC0, 8'h08, 0, "R4 steady while suspended b");
    idle(200);
    chk(busy, 1, "R8 timer frozen");
    resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    chk(suspended, 0, "R8 resumed");
    rd_st(8'hC0, 8'h08, 1, "R4 toggles after resume a");
    rd_st(8'hC0, 8'h08, 1, "R4 toggles after resume b");
    wait_free(400, "R7 bulk erase completes");
    rd(8'hC0, 8'hFF, 8'hFF, "R7 bulk wiped sector3");
    rd(8'h05, 8'h50, 8'hFF, "R7 protected sector kept");

    // R9 protected target
    start_prog(8'h05, 8'h00);
    rd_st(8'h05, 8'h80, 1, "R9 status while ignored a");
    rd_st(8'h05, 8'h80, 1, "R9 status while ignored b");
    wait_free(100, "R9 returns to idle");
    rd(8'h05, 8'h50, 8'hFF, "R9 array unchanged");
    start_se(8'h10, 1);
    wait_free(200, "R9 protected erase ends");
    rd(8'h05, 8'h50, 8'hFF, "R9 erase of protected ignored");

    // R10 retry exhaustion
    fault_inj = 1'b1;
    start_prog(8'h41, 8'h0F);
    n = 0; while (!err && n < 1000) begin @(negedge clk); n++; end
    chk(n, TRIES * P_CYC, "R10 cycles to error");
    fault_inj = 1'b0;
    rd_st(8'h41, 8'hA0, 1, "R10 status bit5");
    idle(50);
    chk(err, 1, "R10 err sticky"); chk(busy, 1, "R10 busy held");
    rd_reset = 1'b1; @(negedge clk); rd_reset = 1'b0;
    chk(err, 0, "R10 cleared by rd_reset"); chk(busy, 0, "R10 idle after reset cmd");
    rd(8'h41, 8'hFF, 8'hFF, "R10 target unchanged");

    idle(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule